// File: doc/BRIEF.md
# Dual-Width Pulse Pair Generator

This block holds two 8-bit down-counters. Each one drives a repeating square wave, and separate reload bytes set the length of the low phase and the length of the high phase. A mode input decides how the two counters are used. They can run as two independent 8-bit generators. They can be fused into a single 16-bit generator. Or counter 0 can act as an 8-bit prescaler whose underflows clock counter 1.

All counting advances on a shared count tick. The tick is the system clock divided by 1, 2, 4, 8 or 16. It can also be an external slow tick that arrives as a one-cycle strobe. Software-side logic writes reload bytes through a small write port. A new byte is sampled only when its phase next begins, so the phase that is already running is never shortened or stretched. When a high phase ends, the block raises a one-cycle period-end strobe.

Top module: `pulse_pair_gen`

## Requirements
- R1: While `rst_n` is low, both `pulse_out` bits and both `period_end` bits are 0, and all reload bytes reset to 0.
- R2: While a generator's enable is 0, its output is low from the next cycle on. After the enable rises, with a divide-by-1 tick, the output first goes high at the (LO+1)-th clock edge after the enable is sampled.
- R3: In split mode (`mode`=0), generator c uses its own reload bytes. It holds `pulse_out[c]` high for (HI+1) count ticks and low for (LO+1) count ticks, repeating. Enable is `ch_en[c]`. The write address is {c, sel}, where sel=0 is the low byte and sel=1 is the high byte.
- R4: `clk_sel` values 0 to 4 give one count tick every 2^`clk_sel` clock cycles. Values 5 to 7 use each `slow_tick` strobe as one count tick.
- R5: In joined mode (`mode`=1), the low width is {LO1,LO0} and the high width is {HI1,HI0}, with channel 0 as the least-significant byte. The waveform appears on `pulse_out[0]` and `period_end[0]`, gated by `ch_en[0]`. `pulse_out[1]` and `period_end[1]` stay 0.
- R6: In prescaled mode (`mode`=2), counter 0 issues one strobe every (LO0+1) count ticks. Counter 1 uses those strobes as its ticks, with widths HI1 and LO1. The output goes to `pulse_out[0]`/`period_end[0]`, gated by `ch_en[0]`, and `pulse_out[1]` stays 0. Mode 3 behaves like mode 0.
- R7: A reload write that lands during a phase does not change the length of that phase. It takes effect the next time that phase begins.
- R8: `period_end[c]` is high for exactly one cycle, the same cycle in which `pulse_out[c]` falls from high to low, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 split, 1 joined 16-bit, 2 prescaled, 3 split |
| clk_sel | input | 3 | Count tick source: 0..4 divide by 2^n, 5..7 slow tick |
| slow_tick | input | 1 | One-cycle external time-base strobe |
| ch_en | input | 2 | Generator enables |
| wr_en | input | 1 | Reload byte write strobe |
| wr_addr | input | 2 | [1] channel, [0] 0=low byte 1=high byte |
| wr_data | input | 8 | Reload byte value |
| pulse_out | output | 2 | Waveform outputs |
| period_end | output | 2 | One-cycle strobe at end of each high phase |

## Verification
Some properties are checked on every cycle by assertions. An idle generator's output sits low. A phase flips only on a count tick. The period-end strobe coincides with a falling output. Divided ticks are never back to back. Other behaviour can only be shown by the bench's scenarios: the exact phase lengths over every divider and several reload pairs, the 16-bit byte ordering, the prescaler multiplication, the slow-tick source, the delay from enable to first high, and the deferred effect of a mid-phase reload write.

// File: rtl/pulse_pair_pkg.sv
package pulse_pair_pkg;
   typedef enum logic [1:0] {
      PAIR_SPLIT = 2'd0,
      PAIR_JOIN  = 2'd1,
      PAIR_PRESC = 2'd2,
      PAIR_ALT   = 2'd3
   } pair_mode_e;
endpackage

// File: rtl/pulse_tick_sel.sv
module pulse_tick_sel #(
   parameter int N_DIV = 5,
   localparam int DIV_W = (N_DIV > 1) ? N_DIV - 1 : 1,
   localparam int SEL_W = $clog2(N_DIV + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             slow_tick,
   output logic             tick
);
   initial begin
      assert (N_DIV >= 1 && N_DIV <= 16) else $error("N_DIV out of range");
   end

   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   always_comb begin
      tick = slow_tick;
      for (int k = 0; k < N_DIV; k++) begin
         if (sel == SEL_W'(k))
            tick = &(div_q | ~({DIV_W{1'b1}} >> (DIV_W - k)));
      end
   end

   // R4: a divided tick (ratio >= 2) never repeats on the next cycle
   assert_div_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != '0 && sel < SEL_W'(N_DIV) && tick) |=> !(tick && $stable(sel)));
endmodule

// File: rtl/pulse_prescaler.sv
module pulse_prescaler #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         tick,
   input  logic [W-1:0] reload,
   output logic         strobe
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!en)   cnt_q <= reload;
      else if (tick)  cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
   end

   assign strobe = en && tick && (cnt_q == '0);
endmodule

// File: rtl/pulse_phase_core.sv
module pulse_phase_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         tick,
   input  logic [W-1:0] lo_val,
   input  logic [W-1:0] hi_val,
   output logic         level,
   output logic         period_end
);
   initial begin
      assert (W >= 2) else $error("counter width too small");
   end

   logic [W-1:0] cnt_q;
   logic         phase_hi_q;
   logic         pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         phase_hi_q <= 1'b0;
         pend_q     <= 1'b0;
      end else if (!en) begin
         cnt_q      <= lo_val;
         phase_hi_q <= 1'b0;
         pend_q     <= 1'b0;
      end else begin
         pend_q <= tick && (cnt_q == '0) && phase_hi_q;
         if (tick) begin
            if (cnt_q == '0) begin
               phase_hi_q <= ~phase_hi_q;
               cnt_q      <= phase_hi_q ? lo_val : hi_val;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign level      = phase_hi_q;
   assign period_end = pend_q;

   // R2: disabled generator is low on the next cycle
   assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !level);
   // R3: phase only flips on a count tick while running
   assert_flip_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && (level != $past(level))) |-> $past(tick));
   // R8: strobe only when the output just fell
   assert_end_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |-> (!level && $past(level)));
endmodule

// File: rtl/pulse_pair_gen.sv
module pulse_pair_gen
   import pulse_pair_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int N_DIV  = 5,
   localparam int SEL_W  = $clog2(N_DIV + 1),
   localparam int WIDE_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [SEL_W-1:0]  clk_sel,
   input  logic              slow_tick,
   input  logic [1:0]        ch_en,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [1:0]        pulse_out,
   output logic [1:0]        period_end
);
   pair_mode_e mode_e;
   assign mode_e = pair_mode_e'(mode);

   logic split_m, join_m, presc_m;
   assign join_m  = (mode_e == PAIR_JOIN);
   assign presc_m = (mode_e == PAIR_PRESC);
   assign split_m = !join_m && !presc_m;

   logic [BYTE_W-1:0] lo_q [2];
   logic [BYTE_W-1:0] hi_q [2];

   for (genvar c = 0; c < 2; c++) begin : g_regs
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q[c] <= '0;
            hi_q[c] <= '0;
         end else if (wr_en && wr_addr[1] == c[0]) begin
            if (wr_addr[0]) hi_q[c] <= wr_data;
            else            lo_q[c] <= wr_data;
         end
      end
   end

   logic tick;
   pulse_tick_sel #(.N_DIV(N_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .sel(clk_sel), .slow_tick(slow_tick), .tick(tick));

   logic pre_strobe;
   pulse_prescaler #(.W(BYTE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(presc_m && ch_en[0]), .tick(tick),
      .reload(lo_q[0]), .strobe(pre_strobe));

   logic [1:0] nar_lvl, nar_end, nar_en, nar_tick;
   assign nar_en[0]   = split_m && ch_en[0];
   assign nar_en[1]   = (split_m && ch_en[1]) || (presc_m && ch_en[0]);
   assign nar_tick[0] = tick;
   assign nar_tick[1] = presc_m ? pre_strobe : tick;

   for (genvar c = 0; c < 2; c++) begin : g_narrow
      pulse_phase_core #(.W(BYTE_W)) u_core (
         .clk(clk), .rst_n(rst_n), .en(nar_en[c]), .tick(nar_tick[c]),
         .lo_val(lo_q[c]), .hi_val(hi_q[c]),
         .level(nar_lvl[c]), .period_end(nar_end[c]));
   end

   logic wide_lvl, wide_end;
   pulse_phase_core #(.W(WIDE_W)) u_wide (
      .clk(clk), .rst_n(rst_n), .en(join_m && ch_en[0]), .tick(tick),
      .lo_val({lo_q[1], lo_q[0]}), .hi_val({hi_q[1], hi_q[0]}),
      .level(wide_lvl), .period_end(wide_end));

   always_comb begin
      if (join_m) begin
         pulse_out  = {1'b0, wide_lvl};
         period_end = {1'b0, wide_end};
      end else if (presc_m) begin
         pulse_out  = {1'b0, nar_lvl[1]};
         period_end = {1'b0, nar_end[1]};
      end else begin
         pulse_out  = nar_lvl;
         period_end = nar_end;
      end
   end
endmodule

// File: tb/pulse_pair_gen_tb_top.sv
module pulse_pair_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = '0;
   logic [2:0] clk_sel = '0;
   logic       slow_tick = 1'b0;
   logic [1:0] ch_en = '0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] pulse_out, period_end;
   logic       slow_on = 1'b0;
   int         slow_cnt = 0;
   int         n_checks = 0;
   int         n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pulse_pair_gen dut_i (
      .clk(clk), .rst_n(rst_n), .mode(mode), .clk_sel(clk_sel),
      .slow_tick(slow_tick), .ch_en(ch_en), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pulse_out(pulse_out), .period_end(period_end));

   always @(negedge clk) begin
      if (slow_on) begin
         slow_cnt  <= (slow_cnt == 2) ? 0 : slow_cnt + 1;
         slow_tick <= (slow_cnt == 2);
      end else begin
         slow_tick <= 1'b0;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic measure(input int idx, input int exp_hi, input int exp_lo, input string req);
      int n = 0, hc = 0, lc = 0, bad = 0;
      while (pulse_out[idx] !== 1'b0 && n < LIMIT) begin @(negedge clk); n++; end
      while (pulse_out[idx] !== 1'b1 && n < LIMIT) begin @(negedge clk); n++; end
      while (pulse_out[idx] === 1'b1 && hc < LIMIT) begin
         if (period_end[idx] !== 1'b0) bad++;
         hc++; @(negedge clk);
      end
      check(period_end[idx] === 1'b1, "R8 strobe at fall", int'(period_end[idx]), 1);
      while (pulse_out[idx] === 1'b0 && lc < LIMIT) begin
         if (lc > 0 && period_end[idx] !== 1'b0) bad++;
         lc++; @(negedge clk);
      end
      check(hc == exp_hi, {req, " high width"}, hc, exp_hi);
      check(lc == exp_lo, {req, " low width"}, lc, exp_lo);
      check(bad == 0, "R8 stray strobe", bad, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      int vals[3] = '{0, 1, 3};
      int hc, n;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(pulse_out === 2'b00, "R1 out in reset", int'(pulse_out), 0);
      check(period_end === 2'b00, "R1 strobe in reset", int'(period_end), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(pulse_out === 2'b00, "R1 out after reset", int'(pulse_out), 0);

      // R3 and R4: split mode sweep over dividers and reload pairs
      ch_en = 2'b11;
      for (int s = 0; s < 5; s++) begin
         for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
               clk_sel = 3'(s);
               wr(2'b00, 8'(vals[a]));
               wr(2'b01, 8'(vals[b]));
               wr(2'b10, 8'(vals[b]));
               wr(2'b11, 8'(vals[a] + 2));
               measure(0, (vals[b] + 1) << s, (vals[a] + 1) << s, "R3 R4 ch0");
               measure(1, (vals[a] + 3) << s, (vals[b] + 1) << s, "R3 R4 ch1");
            end
         end
      end

      // R4: slow tick source
      slow_on = 1'b1;
      clk_sel = 3'd5;
      wr(2'b00, 8'd1);
      wr(2'b01, 8'd2);
      measure(0, 9, 6, "R4 slow tick");
      slow_on = 1'b0;

      // R2: disable and restart delay
      clk_sel = 3'd0;
      ch_en = 2'b00;
      wr(2'b00, 8'd4);
      repeat (2) @(negedge clk);
      check(pulse_out === 2'b00, "R2 idle low", int'(pulse_out), 0);
      ch_en = 2'b01;
      n = 0;
      do begin @(negedge clk); n++; end while (pulse_out[0] !== 1'b1 && n < LIMIT);
      check(n == 5, "R2 first high edge", n, 5);

      // R7: mid-phase write to high byte
      wr(2'b00, 8'd10);
      wr(2'b01, 8'd20);
      n = 0;
      while (pulse_out[0] !== 1'b0 && n < LIMIT) begin @(negedge clk); n++; end
      while (pulse_out[0] !== 1'b1 && n < LIMIT) begin @(negedge clk); n++; end
      hc = 1;
      forever begin
         @(negedge clk);
         if (pulse_out[0] !== 1'b1 || hc > LIMIT) break;
         hc++;
         if (hc == 3) begin wr_en = 1'b1; wr_addr = 2'b01; wr_data = 8'd5; end
         else if (hc == 4) wr_en = 1'b0;
      end
      check(hc == 21, "R7 running phase kept", hc, 21);
      measure(0, 6, 11, "R7 new value next phase");

      // R5: joined 16-bit mode
      ch_en = 2'b00;
      mode = 2'd1;
      wr(2'b00, 8'd2);
      wr(2'b10, 8'd1);
      wr(2'b01, 8'd3);
      wr(2'b11, 8'd0);
      ch_en = 2'b01;
      measure(0, 4, 259, "R5 joined");
      n = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (pulse_out[1] !== 1'b0 || period_end[1] !== 1'b0) n++;
      end
      check(n == 0, "R5 upper output quiet", n, 0);

      // R6: prescaled mode
      ch_en = 2'b00;
      mode = 2'd2;
      clk_sel = 3'd1;
      wr(2'b00, 8'd2);
      wr(2'b11, 8'd1);
      wr(2'b10, 8'd2);
      ch_en = 2'b01;
      measure(0, 12, 18, "R6 prescaled");
      check(pulse_out[1] === 1'b0, "R6 upper output quiet", int'(pulse_out[1]), 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule